// File: doc/BRIEF.md
# Quad Two-Stage DAC Code Register Bank

This block keeps the digital state behind four voltage-output DAC channels. Every channel owns a staging (input) register, an active code register that drives the converter, and a sleep flag. A serial front end hands it a decoded command word: a 4-bit opcode, a 4-bit channel select and a 16-bit data field. A single-cycle `exec` strobe accompanies the word, and the bank applies the action to one channel or to all four.

Staging and activation are separate steps. Software can therefore preload several channels and then switch them in the same cycle. Any action that activates a code also wakes a sleeping channel. A per-channel `settled` flag stays low for a programmable wake-up time. That time is longer when the whole bank had been asleep, because the shared bias must restart, and longer again in low-supply mode. An asynchronous active-low clear forces every code register to the reset value. A parameter selects that value, either zero or midscale, and power-on reset uses the same value.

Top module: `quad_dac_regbank`

## Requirements
- R1: After power-on reset (`rst_n` low), every staging and active register holds the reset value. The reset value is 0, or 2^(RES-1) when MID_RESET=1. All `sleep` bits are 0 and all `settled` bits are 1.
- R2: Opcode 0000 loads the data into the staging register of the selected channel(s). `code_out` does not change.
- R3: Opcode 0001 copies the staging register of the selected channel(s) into the active register and clears their `sleep` bit.
- R4: Opcode 0010 loads the data into the staging register(s) of the selected channel(s). In the same cycle it copies all four staging registers, including the new value, to the active registers and wakes all four channels.
- R5: Opcode 0011 loads the data into both the staging and active registers of the selected channel(s) and wakes them.
- R6: Opcode 0100 sets `sleep` for the selected channel(s) and ignores the data field. It leaves every staging and active register unchanged. A channel with `sleep` set shows `settled` = 0.
- R7: Select code k (0 to 3) addresses channel k. Channel k's code appears at `code_out[16*k +: RES]`. Select code 1111 addresses all four channels.
- R8: Opcode 1111, every other opcode not listed above, and every select code from 0100 to 1110 change no state.
- R9: While `clr_n` is low, all staging and active registers are forced to the reset value at once, without waiting for a clock. `sleep` is unaffected.
- R10: A channel woken while at least one channel was awake shows `settled` = 0 for exactly SHORT_US*CLK_MHZ cycles after the activating edge.
- R11: If all four channels were asleep, a woken channel shows `settled` = 0 for LONG_US*CLK_MHZ cycles. When `low_supply` = 1, the delay is SLOW_US*CLK_MHZ cycles instead.
- R12: The stored code is `data[15 -: RES]`. The low 16-RES data bits are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| clr_n | input | 1 | Asynchronous code clear, active low |
| exec | input | 1 | One-cycle strobe executing the present command word |
| cmd | input | 4 | Opcode |
| addr | input | 4 | Channel select |
| data | input | 16 | Left-aligned code field |
| low_supply | input | 1 | Selects the longer full-bank wake-up delay |
| code_out | output | 64 | Active codes, channel k in bits 16k upward |
| sleep | output | 4 | Per-channel power-down flags |
| settled | output | 4 | Per-channel awake-and-settled flags |

## Verification
Directed sequences first separate staging from activation. A write alone must leave the outputs still, and the code shows only after a later update. Single-channel selects are contrasted with the all-channel select, and reserved opcodes and selects with valid ones. Wake-up is tried from three starting points: a partly awake bank, a fully asleep bank, and a fully asleep bank in low-supply mode. Each is sampled one cycle before and exactly at the end of its delay, so the short and long timers cannot be mistaken for each other. A long random mix of opcodes, selects, data and idle gaps is then compared each step against a bench model. This exposes ordering faults such as an update of all channels reading a stale staging value.

// File: rtl/quad_dac_regbank.sv
module quad_dac_regbank #(
  parameter int RES       = 16,
  parameter bit MID_RESET = 1'b0,
  parameter int CLK_MHZ   = 250,
  parameter int SHORT_US  = 5,
  parameter int LONG_US   = 12,
  parameter int SLOW_US   = 30
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clr_n,
  input  logic        exec,
  input  logic [3:0]  cmd,
  input  logic [3:0]  addr,
  input  logic [15:0] data,
  input  logic        low_supply,
  output logic [63:0] code_out,
  output logic [3:0]  sleep,
  output logic [3:0]  settled
);
  localparam int NCH       = 4;
  localparam int SHORT_CYC = SHORT_US * CLK_MHZ;
  localparam int LONG_CYC  = LONG_US * CLK_MHZ;
  localparam int SLOW_CYC  = SLOW_US * CLK_MHZ;
  localparam int CW        = $clog2(SLOW_CYC + 1);
  localparam logic [RES-1:0] MIDCODE = {1'b1, {(RES-1){1'b0}}};
  localparam logic [RES-1:0] INIT    = MID_RESET ? MIDCODE : '0;

  logic [RES-1:0] stage_q [NCH];
  logic [RES-1:0] act_q   [NCH];
  logic [CW-1:0]  cnt_q   [NCH];
  logic [NCH-1:0] sleep_q;
  logic [NCH-1:0] sel, wr_m, up_m, dn_m, wake_m;
  logic [CW-1:0]  dly;
  logic           go;
  logic           wipe_n;

  wire [RES-1:0] din = data[15 -: RES];

  assign wipe_n = rst_n & clr_n;
  assign go     = exec & ((addr < 4'd4) | (addr == 4'hF));

  always_comb begin
    for (int i = 0; i < NCH; i++)
      sel[i] = (addr == 4'(i)) | (addr == 4'hF);
    wr_m = '0;
    up_m = '0;
    dn_m = '0;
    if (go) begin
      case (cmd)
        4'b0000: wr_m = sel;
        4'b0001: up_m = sel;
        4'b0010: begin wr_m = sel; up_m = '1; end
        4'b0011: begin wr_m = sel; up_m = sel; end
        4'b0100: dn_m = sel;
        default: ;
      endcase
    end
  end

  assign wake_m = up_m & sleep_q;
  assign dly = (&sleep_q) ? (low_supply ? CW'(SLOW_CYC) : CW'(LONG_CYC))
                          : CW'(SHORT_CYC);

  always_ff @(posedge clk or negedge wipe_n) begin
    if (!wipe_n) begin
      for (int i = 0; i < NCH; i++) begin
        stage_q[i] <= INIT;
        act_q[i]   <= INIT;
      end
    end else begin
      for (int i = 0; i < NCH; i++) begin
        if (wr_m[i]) stage_q[i] <= din;
        if (up_m[i]) act_q[i]   <= wr_m[i] ? din : stage_q[i];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sleep_q <= '0;
      for (int i = 0; i < NCH; i++) cnt_q[i] <= '0;
    end else begin
      for (int i = 0; i < NCH; i++) begin
        if (dn_m[i]) begin
          sleep_q[i] <= 1'b1;
          cnt_q[i]   <= '0;
        end else begin
          if (up_m[i]) sleep_q[i] <= 1'b0;
          if (wake_m[i])            cnt_q[i] <= dly;
          else if (cnt_q[i] != '0)  cnt_q[i] <= cnt_q[i] - 1'b1;
        end
      end
    end
  end

  for (genvar g = 0; g < NCH; g++) begin : g_out
    assign code_out[16*g +: 16] = 16'(act_q[g]);
    assign settled[g] = ~sleep_q[g] & (cnt_q[g] == '0);
  end
  assign sleep = sleep_q;
endmodule

// File: rtl/quad_dac_regbank_chk.sv
module quad_dac_regbank_chk #(
  parameter int RES       = 16,
  parameter bit MID_RESET = 1'b0
) (
  input logic        clk,
  input logic        rst_n,
  input logic        clr_n,
  input logic        exec,
  input logic [3:0]  cmd,
  input logic [3:0]  addr,
  input logic [63:0] code_out,
  input logic [3:0]  sleep,
  input logic [3:0]  settled
);
  localparam logic [15:0] INIT16 = MID_RESET ? 16'(1 << (RES-1)) : 16'h0;

  a_r9_clear_forces_init: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_n |-> code_out == {4{INIT16}});

  a_r2_write_keeps_active: assert property (@(posedge clk) disable iff (!rst_n || !clr_n)
    exec && cmd == 4'b0000 |=> $stable(code_out));

  a_r6_pd_all_sleeps: assert property (@(posedge clk) disable iff (!rst_n || !clr_n)
    exec && cmd == 4'b0100 && addr == 4'hF |=> sleep == 4'hF && $stable(code_out));

  a_r3_update_wakes: assert property (@(posedge clk) disable iff (!rst_n)
    exec && cmd == 4'b0001 && addr == 4'h0 |=> !sleep[0]);

  a_r10_wake_not_settled: assert property (@(posedge clk) disable iff (!rst_n)
    exec && cmd == 4'b0001 && addr == 4'h0 && sleep[0] |=> !settled[0]);

  a_r8_reserved_cmd_idle: assert property (@(posedge clk) disable iff (!rst_n || !clr_n)
    exec && cmd > 4'b0100 |=> $stable(code_out) && $stable(sleep));

  a_r6_settled_needs_power: assert property (@(posedge clk) disable iff (!rst_n)
    (settled & sleep) == 4'h0);
endmodule

bind quad_dac_regbank quad_dac_regbank_chk #(.RES(RES), .MID_RESET(MID_RESET)) u_chk (
  .clk(clk), .rst_n(rst_n), .clr_n(clr_n), .exec(exec), .cmd(cmd), .addr(addr),
  .code_out(code_out), .sleep(sleep), .settled(settled));

// File: tb/quad_dac_regbank_bench.sv
module quad_dac_regbank_bench;
  localparam int SHORT_D = 5 * 250;
  localparam int LONG_D  = 12 * 250;
  localparam int SLOW_D  = 30 * 250;

  logic clk = 1'b0;
  logic rst_n = 1'b0, clr_n = 1'b1, exec = 1'b0, low_supply = 1'b0;
  logic [3:0] cmd = '0, addr = '0;
  logic [15:0] data = '0;
  logic [63:0] code_out, code_alt;
  logic [3:0] sleep, settled, sleep_alt, settled_alt;

  int nchk = 0, nfail = 0;
  int m_stage[4], m_act[4], m_cnt[4];
  bit m_sl[4];

  always #2 clk = ~clk;

  quad_dac_regbank u_quad_dac_regbank (
    .clk(clk), .rst_n(rst_n), .clr_n(clr_n), .exec(exec), .cmd(cmd), .addr(addr),
    .data(data), .low_supply(low_supply), .code_out(code_out), .sleep(sleep),
    .settled(settled));

  quad_dac_regbank #(.RES(12), .MID_RESET(1'b1)) u_alt (
    .clk(clk), .rst_n(rst_n), .clr_n(clr_n), .exec(exec), .cmd(cmd), .addr(addr),
    .data(data), .low_supply(low_supply), .code_out(code_alt), .sleep(sleep_alt),
    .settled(settled_alt));

  always @(posedge clk) begin
    if (rst_n) begin
      bit ok, all_sl;
      bit s[4], wr[4], up[4], dn[4];
      ok = (addr < 4) || (addr == 4'hF);
      all_sl = m_sl[0] && m_sl[1] && m_sl[2] && m_sl[3];
      for (int i = 0; i < 4; i++) begin
        s[i] = (addr == 4'(i)) || (addr == 4'hF);
        wr[i] = exec && ok && s[i] && (cmd == 0 || cmd == 2 || cmd == 3);
        up[i] = exec && ok && ((s[i] && (cmd == 1 || cmd == 3)) || cmd == 2);
        dn[i] = exec && ok && s[i] && cmd == 4;
      end
      for (int i = 0; i < 4; i++) begin
        if (up[i]) m_act[i] = wr[i] ? int'(data) : m_stage[i];
        if (wr[i]) m_stage[i] = int'(data);
        if (dn[i]) begin
          m_sl[i] = 1; m_cnt[i] = 0;
        end else begin
          if (up[i] && m_sl[i])
            m_cnt[i] = all_sl ? (low_supply ? SLOW_D : LONG_D) : SHORT_D;
          else if (m_cnt[i] > 0) m_cnt[i]--;
          if (up[i]) m_sl[i] = 0;
        end
      end
    end
  end

  task automatic chk(string req, logic [63:0] got, logic [63:0] exp);
    nchk++;
    if (got !== exp) begin
      nfail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic cmp_model(string req);
    logic [63:0] ec;
    logic [3:0] es, ep;
    for (int i = 0; i < 4; i++) begin
      ec[16*i +: 16] = 16'(m_act[i]);
      es[i] = m_sl[i];
      ep[i] = !m_sl[i] && m_cnt[i] == 0;
    end
    chk({req, " code"}, code_out, ec);
    chk({req, " sleep"}, {60'h0, sleep}, {60'h0, es});
    chk({req, " settled"}, {60'h0, settled}, {60'h0, ep});
  endtask

  task automatic op(logic [3:0] c, logic [3:0] a, logic [15:0] d);
    @(negedge clk);
    exec = 1'b1; cmd = c; addr = a; data = d;
    @(negedge clk);
    exec = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  endtask

  initial begin
    #800000;
    nfail++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
  end

  initial begin
    for (int i = 0; i < 4; i++) begin
      m_stage[i] = 0; m_act[i] = 0; m_cnt[i] = 0; m_sl[i] = 0;
    end
    idle(3);
    rst_n = 1'b1;
    idle(1);
    // R1 reset values, R12 midscale for the 12-bit variant
    cmp_model("R1 reset");
    chk("R1 R12 alt reset midscale", code_alt, {4{16'h0800}});
    chk("R1 alt settled", {60'h0, settled_alt}, 64'hF);

    op(4'b0000, 4'h0, 16'h1234);
    chk("R2 write keeps active", code_out, 64'h0);
    op(4'b0001, 4'h0, 16'hFFFF);
    chk("R3 update ch0", code_out, 64'h0000_0000_0000_1234);
    op(4'b0000, 4'hF, 16'hABCD);
    op(4'b0001, 4'hF, 16'h0000);
    chk("R7 all-channel select", code_out, {4{16'hABCD}});
    op(4'b0011, 4'h2, 16'h5555);
    chk("R5 R7 write-update ch2", code_out, 64'hABCD_5555_ABCD_ABCD);
    op(4'b0000, 4'h1, 16'h1111);
    op(4'b0010, 4'h3, 16'h2222);
    chk("R4 write then update all", code_out, 64'h2222_5555_1111_ABCD);
    cmp_model("R4 model");

    op(4'b0100, 4'h1, 16'hFFFF);
    chk("R6 sleep ch1 code kept", code_out, 64'h2222_5555_1111_ABCD);
    chk("R6 sleep flag", {60'h0, sleep}, 64'h2);
    chk("R6 settled low asleep", {60'h0, settled}, 64'hD);
    op(4'b0001, 4'h1, 16'h0000);
    chk("R10 woken not settled", {63'h0, settled[1]}, 64'h0);
    idle(SHORT_D - 1);
    chk("R10 one cycle before end", {63'h0, settled[1]}, 64'h0);
    idle(1);
    chk("R10 settled at end", {63'h0, settled[1]}, 64'h1);
    cmp_model("R10 model");

    op(4'b0100, 4'hF, 16'h0000);
    op(4'b0001, 4'h0, 16'h0000);
    idle(LONG_D - 1);
    chk("R11 long delay pending", {63'h0, settled[0]}, 64'h0);
    idle(1);
    chk("R11 long delay done", {63'h0, settled[0]}, 64'h1);
    op(4'b0100, 4'h0, 16'h0000);
    low_supply = 1'b1;
    op(4'b0011, 4'hF, 16'h7777);
    idle(SLOW_D - 1);
    chk("R11 low-supply pending", {60'h0, settled}, 64'h0);
    idle(1);
    chk("R11 low-supply done", {60'h0, settled}, 64'hF);
    low_supply = 1'b0;
    cmp_model("R11 model");

    op(4'b0111, 4'h0, 16'h0101);
    op(4'b0000, 4'h9, 16'h0202);
    op(4'b1111, 4'hF, 16'h0303);
    op(4'b0011, 4'h6, 16'h0404);
    chk("R8 reserved no change", code_out, {4{16'h7777}});
    op(4'b0001, 4'hF, 16'h0000);
    chk("R8 staging untouched", code_out, {4{16'h7777}});

    op(4'b0000, 4'hF, 16'h3C3C);
    op(4'b0100, 4'h3, 16'h0000);
    @(negedge clk);
    clr_n = 1'b0;
    for (int i = 0; i < 4; i++) begin m_stage[i] = 0; m_act[i] = 0; end
    #1;
    chk("R9 async clear", code_out, 64'h0);
    chk("R9 alt clear midscale", code_alt, {4{16'h0800}});
    chk("R9 sleep kept", {60'h0, sleep}, 64'h8);
    @(negedge clk);
    clr_n = 1'b1;
    op(4'b0001, 4'hF, 16'h0000);
    chk("R9 staging cleared", code_out, 64'h0);
    op(4'b0011, 4'h0, 16'hABCF);
    chk("R12 low bits ignored", {48'h0, code_alt[15:0]}, 64'h0ABC);
    cmp_model("R12 model");

    begin
      int seed = 32'h5EED;
      void'($urandom(seed));
    end
    for (int n = 0; n < 500; n++) begin
      logic [3:0] c, a;
      int pick;
      pick = $urandom_range(0, 9);
      c = (pick < 6) ? 4'(pick % 5) : (pick < 8 ? 4'b0100 : 4'($urandom_range(5, 15)));
      pick = $urandom_range(0, 9);
      a = (pick < 7) ? 4'(pick % 4) : (pick < 9 ? 4'hF : 4'($urandom_range(4, 14)));
      low_supply = 1'($urandom_range(0, 1));
      op(c, a, 16'($urandom));
      cmp_model("R2 R3 R4 R5 R6 R8 random");
      idle($urandom_range(0, 3));
      cmp_model("R10 R11 random idle");
    end
    summary();
  end
endmodule